// File: doc/BRIEF.md
# Simple Dual-Port Word Memory with Selectable Collision Policy

This block is a 512-word by 72-bit memory with one port that only reads and one port that only writes. Each port has its own clock. Each 72-bit word is split into eight lanes. A lane holds one data byte and one parity bit. The write port updates any subset of lanes through per-lane enables. The read port returns the word through an array-side latch. An optional pipeline register can follow the latch.

Each port has an address-enable input. When it is low, the port reuses the address it last captured. This lets a caller keep streaming from or into the same word without driving the address again.

A read and a write to the same word on the same clock edge is a collision. A parameter decides what the read side returns in that case: the stored word before the write, the word as it is after the write, or the previous read output unchanged. Collision behaviour is defined only when both ports run from one common clock.

Top module: `sdpram_dual`

## Requirements
- R1: A word written at address A can be read back at A. With `OUT_REG=0`, `rd_dout`/`rd_doutp` show the word one read-clock edge after the edge that samples `rd_en`=1.
- R2: With `OUT_REG=1`, read data appears one edge later than in R1. The pipeline register loads the latch value on every edge where `rd_regce`=1 and `rd_rst_reg`=0.
- R3: Lane i (i = 0..7) is written when `wr_en`=1 and `wr_be[i]`=1. It takes `wr_din[8i+7:8i]` as its data byte and `wr_dinp[i]` as its parity bit. Lanes whose enable is 0 keep their stored contents.
- R4: No word changes when `wr_en`=0, whatever `wr_be` holds. No word changes when `wr_be`=0, whatever `wr_en` holds.
- R5: When `rd_en`=0 and `rd_rst_ram`=0, the latch output keeps its value.
- R6: When a port's address enable is 0, that port uses the address it captured on the last edge where the enable was 1.
- R7: In read-first mode, a collision returns the word as stored before the write.
- R8: In write-first mode, a collision returns the written lanes with new contents and the unwritten lanes with old contents.
- R9: In no-change mode, a collision leaves the read latch unchanged. The write still takes effect.
- R10: `rd_rst_ram`=1 on a read-clock edge clears the latch to zero, whatever `rd_en` holds.
- R11: `rd_rst_reg`=1 clears the pipeline register only on edges where `rd_regce`=1. While `rd_regce`=0 the register holds its value.
- R12: A read and a write to different addresses on the same edge do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_clk | input | 1 | Read-port clock |
| rd_en | input | 1 | Read enable for the array latch |
| rd_addr_en | input | 1 | Capture a new read address; when 0, reuse the held address |
| rd_addr | input | 9 | Read word address |
| rd_rst_ram | input | 1 | Synchronous clear of the array latch |
| rd_regce | input | 1 | Clock enable of the output pipeline register |
| rd_rst_reg | input | 1 | Synchronous clear of the pipeline register, gated by rd_regce |
| rd_dout | output | 64 | Read data bytes |
| rd_doutp | output | 8 | Read parity bits, one per lane |
| wr_clk | input | 1 | Write-port clock |
| wr_en | input | 1 | Write enable |
| wr_addr_en | input | 1 | Capture a new write address; when 0, reuse the held address |
| wr_addr | input | 9 | Write word address |
| wr_be | input | 8 | Per-lane write enables |
| wr_din | input | 64 | Write data bytes |
| wr_dinp | input | 8 | Write parity bits, one per lane |

## Verification
A read and a write can land on the same word on the same edge, and the read side must then follow the chosen collision policy. The bench drives both ports from one clock and steers both addresses into an eight-word window. It mixes partial lane enables with held addresses, so collisions occur often, including cases where only one side's address comes from its hold register. Three instances, one per policy, see identical stimulus. A behavioural model predicts each output on every edge: the old word, the lane-merged new word, or the unchanged previous value.

// File: rtl/sdpram_pkg.sv
`timescale 1ns/1ps
package sdpram_pkg;
   typedef enum logic [1:0] {
      WM_READ_FIRST  = 2'd0,
      WM_WRITE_FIRST = 2'd1,
      WM_NO_CHANGE   = 2'd2
   } wr_mode_e;
endpackage

// File: rtl/sdpram_addr_hold.sv
`timescale 1ns/1ps
// Address capture: a live address when enabled, else the last captured one.
module sdpram_addr_hold #(
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              addr_en,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_eff
);
   logic [ADDR_W-1:0] held_q;

   always_ff @(posedge clk) begin
      if (addr_en) held_q <= addr_in;
   end

   assign addr_eff = addr_en ? addr_in : held_q;
endmodule

// File: rtl/sdpram_store.sv
`timescale 1ns/1ps
// Lane-sliced storage: one array per lane so each lane enable owns its slice.
module sdpram_store #(
   parameter int ADDR_W = 9,
   parameter int LANES  = 8,
   parameter int LANE_W = 9
) (
   input  logic                    wr_clk,
   input  logic                    wr_en,
   input  logic [LANES-1:0]        wr_be,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [LANES*LANE_W-1:0] wr_word,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [LANES*LANE_W-1:0] rd_word
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] lane_mem [DEPTH];

      always_ff @(posedge wr_clk) begin
         if (wr_en && wr_be[g]) lane_mem[wr_addr] <= wr_word[g*LANE_W +: LANE_W];
      end

      assign rd_word[g*LANE_W +: LANE_W] = lane_mem[rd_addr];
   end
endmodule

// File: rtl/sdpram_rd_latch.sv
`timescale 1ns/1ps
// Array-side read latch with collision policy selection.
module sdpram_rd_latch #(
   parameter int ADDR_W = 9,
   parameter int LANES  = 8,
   parameter int LANE_W = 9,
   parameter sdpram_pkg::wr_mode_e MODE = sdpram_pkg::WM_READ_FIRST
) (
   input  logic                    rd_clk,
   input  logic                    rst_ram,
   input  logic                    rd_en,
   input  logic [ADDR_W-1:0]       rd_addr,
   input  logic [LANES*LANE_W-1:0] arr_word,
   input  logic                    wr_en,
   input  logic [LANES-1:0]        wr_be,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [LANES*LANE_W-1:0] wr_word,
   output logic [LANES*LANE_W-1:0] lat_q
);
   localparam int WORD_W = LANES * LANE_W;

   logic              hit;
   logic [WORD_W-1:0] merged;
   logic [WORD_W-1:0] next_word;

   assign hit = wr_en && (|wr_be) && (wr_addr == rd_addr);

   for (genvar g = 0; g < LANES; g++) begin : g_merge
      assign merged[g*LANE_W +: LANE_W] = wr_be[g] ? wr_word[g*LANE_W +: LANE_W]
                                                   : arr_word[g*LANE_W +: LANE_W];
   end

   if (MODE == sdpram_pkg::WM_WRITE_FIRST) begin : g_wf
      assign next_word = hit ? merged : arr_word;
   end else if (MODE == sdpram_pkg::WM_NO_CHANGE) begin : g_nc
      assign next_word = hit ? lat_q : arr_word;
   end else begin : g_rf
      assign next_word = arr_word;
   end

   always_ff @(posedge rd_clk) begin
      if (rst_ram)    lat_q <= '0;
      else if (rd_en) lat_q <= next_word;
   end
endmodule

// File: rtl/sdpram_out_stage.sv
`timescale 1ns/1ps
// Optional output pipeline register with gated synchronous clear.
module sdpram_out_stage #(
   parameter int WORD_W  = 72,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              regce,
   input  logic              rst_reg,
   input  logic [WORD_W-1:0] d,
   output logic [WORD_W-1:0] q
);
   if (OUT_REG) begin : g_reg
      logic [WORD_W-1:0] q_r;
      always_ff @(posedge clk) begin
         if (regce) q_r <= rst_reg ? '0 : d;
      end
      assign q = q_r;
   end else begin : g_pass
      logic unused_ok;
      assign unused_ok = &{1'b0, regce, rst_reg};
      assign q = d;
   end
endmodule

// File: rtl/sdpram_dual.sv
`timescale 1ns/1ps
module sdpram_dual #(
   parameter int ADDR_W = 9,
   parameter int LANES  = 8,
   parameter int BYTE_W = 8,
   parameter sdpram_pkg::wr_mode_e MODE = sdpram_pkg::WM_READ_FIRST,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                    rd_clk,
   input  logic                    rd_en,
   input  logic                    rd_addr_en,
   input  logic [ADDR_W-1:0]       rd_addr,
   input  logic                    rd_rst_ram,
   input  logic                    rd_regce,
   input  logic                    rd_rst_reg,
   output logic [LANES*BYTE_W-1:0] rd_dout,
   output logic [LANES-1:0]        rd_doutp,
   input  logic                    wr_clk,
   input  logic                    wr_en,
   input  logic                    wr_addr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [LANES-1:0]        wr_be,
   input  logic [LANES*BYTE_W-1:0] wr_din,
   input  logic [LANES-1:0]        wr_dinp
);
   localparam int LANE_W = BYTE_W + 1;
   localparam int WORD_W = LANES * LANE_W;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("sdpram_dual: ADDR_W out of supported range");
   end
   if (LANES < 1 || BYTE_W < 1) begin : g_bad_lane
      $error("sdpram_dual: LANES and BYTE_W must be positive");
   end

   logic [ADDR_W-1:0] rd_addr_eff, wr_addr_eff;
   logic [WORD_W-1:0] wr_word, arr_word, lat_q, out_word;

   for (genvar g = 0; g < LANES; g++) begin : g_pack
      assign wr_word[g*LANE_W +: LANE_W] = {wr_dinp[g], wr_din[g*BYTE_W +: BYTE_W]};
      assign rd_dout[g*BYTE_W +: BYTE_W] = out_word[g*LANE_W +: BYTE_W];
      assign rd_doutp[g]                 = out_word[g*LANE_W + BYTE_W];
   end

   sdpram_addr_hold #(.ADDR_W(ADDR_W)) u_rd_addr (
      .clk(rd_clk), .addr_en(rd_addr_en), .addr_in(rd_addr), .addr_eff(rd_addr_eff));

   sdpram_addr_hold #(.ADDR_W(ADDR_W)) u_wr_addr (
      .clk(wr_clk), .addr_en(wr_addr_en), .addr_in(wr_addr), .addr_eff(wr_addr_eff));

   sdpram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
      .wr_clk(wr_clk), .wr_en(wr_en), .wr_be(wr_be), .wr_addr(wr_addr_eff),
      .wr_word(wr_word), .rd_addr(rd_addr_eff), .rd_word(arr_word));

   sdpram_rd_latch #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .MODE(MODE)) u_latch (
      .rd_clk(rd_clk), .rst_ram(rd_rst_ram), .rd_en(rd_en), .rd_addr(rd_addr_eff),
      .arr_word(arr_word), .wr_en(wr_en), .wr_be(wr_be), .wr_addr(wr_addr_eff),
      .wr_word(wr_word), .lat_q(lat_q));

   sdpram_out_stage #(.WORD_W(WORD_W), .OUT_REG(OUT_REG)) u_out (
      .clk(rd_clk), .regce(rd_regce), .rst_reg(rd_rst_reg), .d(lat_q), .q(out_word));
endmodule

// File: rtl/sdpram_chk.sv
`timescale 1ns/1ps
module sdpram_chk #(
   parameter int ADDR_W = 9,
   parameter int LANES  = 8,
   parameter int BYTE_W = 8,
   parameter sdpram_pkg::wr_mode_e MODE = sdpram_pkg::WM_READ_FIRST,
   parameter bit OUT_REG = 1'b1
) (
   input logic                             rd_clk,
   input logic                             rd_en,
   input logic                             rd_addr_en,
   input logic [ADDR_W-1:0]                rd_addr,
   input logic                             rd_rst_ram,
   input logic                             rd_regce,
   input logic                             rd_rst_reg,
   input logic [LANES*BYTE_W-1:0]          rd_dout,
   input logic [LANES-1:0]                 rd_doutp,
   input logic                             wr_en,
   input logic                             wr_addr_en,
   input logic [ADDR_W-1:0]                wr_addr,
   input logic [LANES-1:0]                 wr_be,
   input logic [LANES*(BYTE_W+1)-1:0]      lat
);
   localparam int LANE_W = BYTE_W + 1;
   localparam int WORD_W = LANES * LANE_W;

   logic [WORD_W-1:0] port_word;
   for (genvar g = 0; g < LANES; g++) begin : g_view
      assign port_word[g*LANE_W +: LANE_W] = {rd_doutp[g], rd_dout[g*BYTE_W +: BYTE_W]};
   end

   logic live_hit;
   assign live_hit = rd_addr_en && wr_addr_en && (rd_addr == wr_addr) && wr_en && (|wr_be);

   // R10
   p_rstram_clears_r10: assert property (@(posedge rd_clk)
      rd_rst_ram |=> (lat == '0));

   // R5
   p_rden_low_holds_r5: assert property (@(posedge rd_clk) disable iff (rd_rst_ram)
      !rd_en |=> $stable(lat));

   // R9
   p_nochange_holds_r9: assert property (@(posedge rd_clk) disable iff (rd_rst_ram)
      (MODE == sdpram_pkg::WM_NO_CHANGE) && rd_en && live_hit |=> $stable(lat));

   // R2
   p_pipe_follows_latch_r2: assert property (@(posedge rd_clk) disable iff (rd_rst_ram)
      OUT_REG && rd_regce && !rd_rst_reg |=> (port_word == $past(lat)));

   // R11
   p_regce_low_holds_r11: assert property (@(posedge rd_clk) disable iff (rd_rst_ram)
      OUT_REG && !rd_regce |=> $stable(port_word));

   // R11
   p_rstreg_clears_r11: assert property (@(posedge rd_clk) disable iff (rd_rst_ram)
      OUT_REG && rd_regce && rd_rst_reg |=> (port_word == '0));

   // R1
   p_direct_path_r1: assert property (@(posedge rd_clk)
      !OUT_REG |-> (port_word == lat));
endmodule

bind sdpram_dual sdpram_chk #(
   .ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W), .MODE(MODE), .OUT_REG(OUT_REG)
) u_chk (
   .rd_clk(rd_clk), .rd_en(rd_en), .rd_addr_en(rd_addr_en), .rd_addr(rd_addr),
   .rd_rst_ram(rd_rst_ram), .rd_regce(rd_regce), .rd_rst_reg(rd_rst_reg),
   .rd_dout(rd_dout), .rd_doutp(rd_doutp), .wr_en(wr_en), .wr_addr_en(wr_addr_en),
   .wr_addr(wr_addr), .wr_be(wr_be), .lat(lat_q)
);

// File: tb/tb_sdpram_dual.sv
`timescale 1ns/1ps
module tb_sdpram_dual;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rd_en, rd_addr_en, rst_ram, regce, rst_reg;
   logic        wr_en, wr_addr_en;
   logic [8:0]  rd_addr, wr_addr;
   logic [7:0]  be, dinp;
   logic [63:0] din;
   logic [63:0] d_rf, d_wf, d_nc;
   logic [7:0]  p_rf, p_wf, p_nc;

   sdpram_dual #(.MODE(sdpram_pkg::WM_READ_FIRST), .OUT_REG(1'b0)) dut (
      .rd_clk(clk), .rd_en(rd_en), .rd_addr_en(rd_addr_en), .rd_addr(rd_addr),
      .rd_rst_ram(rst_ram), .rd_regce(regce), .rd_rst_reg(rst_reg),
      .rd_dout(d_rf), .rd_doutp(p_rf), .wr_clk(clk), .wr_en(wr_en),
      .wr_addr_en(wr_addr_en), .wr_addr(wr_addr), .wr_be(be), .wr_din(din), .wr_dinp(dinp));

   sdpram_dual #(.MODE(sdpram_pkg::WM_WRITE_FIRST), .OUT_REG(1'b1)) dut_wf (
      .rd_clk(clk), .rd_en(rd_en), .rd_addr_en(rd_addr_en), .rd_addr(rd_addr),
      .rd_rst_ram(rst_ram), .rd_regce(regce), .rd_rst_reg(rst_reg),
      .rd_dout(d_wf), .rd_doutp(p_wf), .wr_clk(clk), .wr_en(wr_en),
      .wr_addr_en(wr_addr_en), .wr_addr(wr_addr), .wr_be(be), .wr_din(din), .wr_dinp(dinp));

   sdpram_dual #(.MODE(sdpram_pkg::WM_NO_CHANGE), .OUT_REG(1'b0)) dut_nc (
      .rd_clk(clk), .rd_en(rd_en), .rd_addr_en(rd_addr_en), .rd_addr(rd_addr),
      .rd_rst_ram(rst_ram), .rd_regce(regce), .rd_rst_reg(rst_reg),
      .rd_dout(d_nc), .rd_doutp(p_nc), .wr_clk(clk), .wr_en(wr_en),
      .wr_addr_en(wr_addr_en), .wr_addr(wr_addr), .wr_be(be), .wr_din(din), .wr_dinp(dinp));

   // behavioural reference
   logic [63:0] m_d [512];
   logic [7:0]  m_p [512];
   logic [63:0] l_d [3];
   logic [7:0]  l_p [3];
   logic [63:0] q_d;
   logic [7:0]  q_p;
   int ra_h, wa_h;

   int n_chk = 0, n_fail = 0;
   string cur_req = "R10";
   bit done = 1'b0;

   task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_step();
      int ra, wa;
      logic [63:0] od, nd;
      logic [7:0]  op, np;
      bit wrote, coll;
      ra = rd_addr_en ? int'(rd_addr) : ra_h;
      wa = wr_addr_en ? int'(wr_addr) : wa_h;
      if (rd_addr_en) ra_h = int'(rd_addr);
      if (wr_addr_en) wa_h = int'(wr_addr);
      od = m_d[ra]; op = m_p[ra];
      nd = m_d[wa]; np = m_p[wa];
      for (int g = 0; g < 8; g++) begin
         if (wr_en && be[g]) begin
            nd[g*8 +: 8] = din[g*8 +: 8];
            np[g] = dinp[g];
         end
      end
      wrote = wr_en && (be != 8'h00);
      coll  = wrote && (wa == ra);
      if (regce) begin
         q_d = rst_reg ? 64'h0 : l_d[1];
         q_p = rst_reg ? 8'h0  : l_p[1];
      end
      for (int k = 0; k < 3; k++) begin
         if (rst_ram) begin
            l_d[k] = '0; l_p[k] = '0;
         end else if (rd_en) begin
            if (!coll || k == 0) begin
               l_d[k] = od; l_p[k] = op;
            end else if (k == 1) begin
               l_d[k] = nd; l_p[k] = np;
            end
         end
      end
      if (wrote) begin
         m_d[wa] = nd; m_p[wa] = np;
      end
   endtask

   task automatic compare_all();
      check({cur_req, " read-first"},  {p_rf, d_rf}, {l_p[0], l_d[0]});
      check({cur_req, " write-first"}, {p_wf, d_wf}, {q_p, q_d});
      check({cur_req, " no-change"},   {p_nc, d_nc}, {l_p[2], l_d[2]});
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle();
      rd_en = 0; rd_addr_en = 1; rst_ram = 0; regce = 1; rst_reg = 0;
      wr_en = 0; wr_addr_en = 1; be = 8'h00;
   endtask

   function automatic logic [63:0] pat(input int i);
      return {32'(i * 32'h9E3779B1), 32'(~i * 32'h7F4A7C15)};
   endfunction

   initial begin
      for (int i = 0; i < 512; i++) begin m_d[i] = '0; m_p[i] = '0; end
      for (int k = 0; k < 3; k++) begin l_d[k] = '0; l_p[k] = '0; end
      q_d = '0; q_p = '0; ra_h = 0; wa_h = 0;
      idle(); rd_addr = 0; wr_addr = 0; din = '0; dinp = '0;
      rst_ram = 1; rst_reg = 1;
      // R10 reset state
      cur_req = "R10";
      repeat (3) tick();
      check("R10 reset state", {p_rf, d_rf}, 72'h0);
      check("R11 reset state", {p_wf, d_wf}, 72'h0);

      // R1 fill whole array
      idle(); cur_req = "R1";
      for (int i = 0; i < 512; i++) begin
         wr_en = 1; be = 8'hFF; wr_addr = 9'(i); din = pat(i); dinp = 8'(i * 37);
         tick();
      end
      idle();
      // R1 and R2 read sweep
      cur_req = "R2";
      for (int i = 0; i < 40; i++) begin
         rd_en = 1; rd_addr = 9'(i * 13);
         tick();
      end
      rd_en = 0; tick(); tick();
      check("R1 direct read", {p_rf, d_rf}, {8'(((39 * 13) % 512) * 37), pat((39 * 13) % 512)});

      // R3 lane enables
      cur_req = "R3";
      for (int i = 0; i < 16; i++) begin
         wr_en = 1; be = 8'(1 << (i % 8)) | 8'(i * 5); wr_addr = 9'(100 + i);
         din = ~pat(i); dinp = 8'hA5 ^ 8'(i);
         rd_en = 1; rd_addr = 9'(100 + i - 1);
         tick();
      end
      wr_en = 0;
      for (int i = 0; i < 18; i++) begin rd_addr = 9'(100 + i); tick(); end

      // R4 no write without both enables
      cur_req = "R4";
      idle(); wr_en = 0; be = 8'hFF; wr_addr = 9'd200; din = '1; dinp = '1; tick();
      wr_en = 1; be = 8'h00; tick();
      wr_en = 0; rd_en = 1; rd_addr = 9'd200; tick(); tick();
      check("R4 untouched word", {p_rf, d_rf}, {8'(200 * 37), pat(200)});

      // R5 read enable low holds
      cur_req = "R5";
      rd_en = 0;
      for (int i = 0; i < 5; i++) begin rd_addr = 9'(i); tick(); end
      check("R5 held output", {p_nc, d_nc}, {8'(200 * 37), pat(200)});

      // R6 address hold on both ports
      cur_req = "R6";
      rd_en = 1; rd_addr_en = 1; rd_addr = 9'd300; tick();
      rd_addr_en = 0;
      for (int i = 0; i < 4; i++) begin rd_addr = 9'(i + 7); tick(); end
      check("R6 held read address", {p_rf, d_rf}, {8'(300 * 37), pat(300)});
      rd_addr_en = 1; rd_en = 0;
      wr_en = 1; be = 8'hFF; wr_addr_en = 1; wr_addr = 9'd310; din = 64'h1111; dinp = 8'h01; tick();
      wr_addr_en = 0; wr_addr = 9'd311; din = 64'h2222; dinp = 8'h02; tick();
      wr_en = 0; wr_addr_en = 1; rd_en = 1; rd_addr = 9'd310; tick();
      rd_addr = 9'd311; tick();
      check("R6 held write address", {p_rf, d_rf}, {8'(311 * 37), pat(311)});

      // R7 R8 R9 directed collisions
      cur_req = "R7 R8 R9 collision";
      for (int i = 0; i < 12; i++) begin
         rd_en = 1; wr_en = 1; rd_addr = 9'(400 + (i % 3)); wr_addr = rd_addr;
         be = 8'(8'h0F << (i % 5)); din = pat(i + 900); dinp = 8'(i * 11);
         tick();
      end
      // collision with one side held
      rd_addr_en = 0; wr_addr = 9'd401; rd_addr = 9'd7; be = 8'hC3; tick();
      rd_addr_en = 1; wr_addr_en = 0; rd_addr = 9'd401; wr_addr = 9'd3; be = 8'h3C; tick();
      wr_addr_en = 1;

      // R10 latch reset beats read enable
      cur_req = "R10";
      wr_en = 0; rd_en = 1; rst_ram = 1; tick();
      check("R10 clear with rd_en", {p_rf, d_rf}, 72'h0);
      rst_ram = 0; tick();

      // R11 output register controls
      cur_req = "R11";
      rd_addr = 9'd50; tick();
      regce = 0; rd_addr = 9'd51; tick(); tick();
      rst_reg = 1; tick();
      regce = 1; tick();
      rst_reg = 0; tick(); tick();

      // R12 concurrent, different addresses
      cur_req = "R12";
      for (int i = 0; i < 30; i++) begin
         rd_en = 1; wr_en = 1; be = 8'hFF;
         rd_addr = 9'(i * 2); wr_addr = 9'(i * 2 + 1);
         din = pat(i + 5000); dinp = 8'(i);
         tick();
      end

      // mixed random traffic in a narrow window
      cur_req = "R12 mixed";
      for (int i = 0; i < 3000; i++) begin
         rd_en = 1'($urandom % 4 != 0);
         rd_addr_en = 1'($urandom % 5 != 0);
         wr_addr_en = 1'($urandom % 5 != 0);
         rd_addr = 9'($urandom % 8);
         wr_addr = 9'($urandom % 8);
         wr_en = 1'($urandom % 3 != 0);
         be = 8'($urandom);
         din = {32'($urandom), 32'($urandom)};
         dinp = 8'($urandom);
         rst_ram = 1'($urandom % 50 == 0);
         regce = 1'($urandom % 6 != 0);
         rst_reg = 1'($urandom % 20 == 0);
         tick();
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule